// File: doc/BRIEF.md
# Sync Pulse Masking Gate

This block prepares a composite-sync stream for a line-lock phase comparator. Composite sync carries pulses at twice the line rate during the equalizing and vertical intervals. A comparator that is fed those extra pulses loses the correct phase, so this block removes them. It builds a line clock that lags the incoming line clock by a quarter of a line. While that lagging clock is high, it blocks both comparator inputs, which drops every other equalizing pulse. A vertical-interval flag, captured on the same event, blocks the composite-sync input through the vertical interval, which drops the serration pulses. The same lagging clock also freezes a horizontal-clock output that feeds a downstream pulse stretcher.

The masking works only after lock has been established. A raw lock-status pulse is qualified by an up/down saturating counter that has hysteresis. While the loop is unqualified, the lagging clock and the vertical flag are held low, so the comparator sees the full unfiltered stream and can pull in over its whole range. A clamp-disable flag is raised over the same interval. All inputs are sampled on a fast system clock through synchronisers. No derived clock is used.

Top module: `sync_mask_gate`

## Requirements
- R1: On each falling edge of the synchronised twice-line-rate input, `dly_hclk_o` takes the synchronised value of `hclk_in`. With `hclk_in` equal to the twice-rate input divided by two, `dly_hclk_o` is high from about a quarter to about three quarters of each line period.
- R2: While `dly_hclk_o` is high, both `cmp_sync_o` and `cmp_ref_o` are low.
- R3: An internal vertical flag takes the synchronised `vsync_in` on the same falling edges as R1. While the flag is high, `cmp_sync_o` is low and `cmp_ref_o` is not affected.
- R4: `hz_o` follows synchronised `csync_in` while `dly_hclk_o` is low, and it holds its value while `dly_hclk_o` is high.
- R5: While the block is unlocked, `dly_hclk_o` and the vertical flag are held low. `cmp_sync_o` then follows `csync_in` and `cmp_ref_o` follows `hclk_in`.
- R6: A counter in the range 0 to LOCK_MAX counts up each cycle the synchronised `lock_in` is 1 and down each cycle it is 0, saturating at both ends. `unlocked_o` is set when the count reaches 0 and cleared when it reaches LOCK_MAX, so a dropout shorter than the count keeps lock. Including the two synchroniser stages, a lock input held high from a count of 0 clears `unlocked_o` LOCK_MAX+2 cycles later.
- R7: `clamp_dis_o` is 1 while unlocked and 0 while locked.
- R8: During and after synchronous reset, `unlocked_o` and `clamp_dis_o` are 1, and `dly_hclk_o`, `hz_o`, `cmp_sync_o` and `cmp_ref_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the sync inputs |
| rst | input | 1 | Synchronous reset, active high |
| twox_in | input | 1 | Reference at twice the line rate |
| hclk_in | input | 1 | Line clock, the reference divided by two |
| csync_in | input | 1 | Composite sync |
| vsync_in | input | 1 | Vertical-interval flag |
| lock_in | input | 1 | Raw lock-status pulse from the comparator, 1 = no phase error |
| dly_hclk_o | output | 1 | Quarter-line-delayed line clock |
| cmp_sync_o | output | 1 | Gated composite sync to the comparator |
| cmp_ref_o | output | 1 | Gated line clock to the comparator |
| hz_o | output | 1 | Masked horizontal clock to the pulse stretcher |
| unlocked_o | output | 1 | Lock not qualified |
| clamp_dis_o | output | 1 | Clamp disable |

## Verification
The assertions assume that each sync input stays at one level for many system clocks, so the synchronisers never skip a transition. They also assume that `hclk_in` changes only near the rising edges of `twox_in`, never near its falling edges, so the captured line-clock value is well defined. The stimulus produces both references from one phase counter with a 40-cycle twice-rate period and a 80-cycle line period. It changes `csync_in`, `vsync_in` and `lock_in` only in steps that last tens of cycles.

// File: rtl/smg_pkg.sv
package smg_pkg;

  typedef struct packed {
    logic twox;
    logic hclk;
    logic csync;
    logic vsync;
    logic lock;
  } smg_in_t;

  typedef enum logic {
    LK_LOCKED   = 1'b0,
    LK_UNLOCKED = 1'b1
  } lock_state_e;

  // A signal passes only when neither mask is raised
  function automatic logic gate_pass(logic sig, logic mask_a, logic mask_b);
    return sig & ~mask_a & ~mask_b;
  endfunction

  // Falling-edge detect from current and previous sample
  function automatic logic fall_edge(logic cur, logic prev);
    return prev & ~cur;
  endfunction

endpackage

// File: rtl/smg_sync.sv
module smg_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[LAST];
  end
endmodule

// File: rtl/smg_lock_qual.sv
module smg_lock_qual #(
  parameter int LOCK_MAX = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         lock_s,
  output logic                         unlocked,
  output logic [$clog2(LOCK_MAX+1)-1:0] cnt
);
  import smg_pkg::*;
  localparam int CW = $clog2(LOCK_MAX + 1);
  localparam logic [CW-1:0] TOP = CW'(LOCK_MAX);

  function automatic logic [CW-1:0] sat_step(logic [CW-1:0] c, logic up);
    if (up)  return (c == TOP)   ? c : c + 1'b1;
    else     return (c == '0)    ? c : c - 1'b1;
  endfunction

  lock_state_e st_q;
  logic [CW-1:0] cnt_q, cnt_nx;

  assign cnt_nx = sat_step(cnt_q, lock_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      st_q  <= LK_UNLOCKED;
    end else begin
      cnt_q <= cnt_nx;
      if (cnt_nx == '0)      st_q <= LK_UNLOCKED;
      else if (cnt_nx == TOP) st_q <= LK_LOCKED;
    end
  end

  assign unlocked = (st_q == LK_UNLOCKED);
  assign cnt      = cnt_q;
endmodule

// File: rtl/smg_dly_gen.sv
module smg_dly_gen (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic twox_s,
  input  logic hclk_s,
  input  logic vsync_s,
  output logic dly,
  output logic vs,
  output logic twox_fall
);
  import smg_pkg::*;
  logic twox_d, dly_q, vs_q;

  assign twox_fall = fall_edge(twox_s, twox_d);

  always_ff @(posedge clk) begin
    if (rst) twox_d <= 1'b0;
    else     twox_d <= twox_s;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dly_q <= 1'b0;
      vs_q  <= 1'b0;
    end else if (twox_fall) begin
      dly_q <= hclk_s;
      vs_q  <= vsync_s;
    end
  end

  assign dly = dly_q;
  assign vs  = vs_q;
endmodule

// File: rtl/sync_mask_gate.sv
module sync_mask_gate #(
  parameter int LOCK_MAX    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic twox_in,
  input  logic hclk_in,
  input  logic csync_in,
  input  logic vsync_in,
  input  logic lock_in,
  output logic dly_hclk_o,
  output logic cmp_sync_o,
  output logic cmp_ref_o,
  output logic hz_o,
  output logic unlocked_o,
  output logic clamp_dis_o
);
  import smg_pkg::*;
  localparam int CW = $clog2(LOCK_MAX + 1);
  localparam int IW = $bits(smg_in_t);

  smg_in_t       raw, syn;
  logic [IW-1:0] syn_v;
  logic          hclk_s, twox_fall, vs_q, dly_q, unl;
  logic [CW-1:0] lock_cnt;
  logic          hz_q;

  assign raw = '{twox: twox_in, hclk: hclk_in, csync: csync_in,
                 vsync: vsync_in, lock: lock_in};

  smg_sync #(.W(IW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d_i (raw), .q_o (syn_v)
  );
  assign syn    = smg_in_t'(syn_v);
  assign hclk_s = syn.hclk;

  smg_lock_qual #(.LOCK_MAX(LOCK_MAX)) u_lock (
    .clk (clk), .rst (rst), .lock_s (syn.lock),
    .unlocked (unl), .cnt (lock_cnt)
  );

  smg_dly_gen u_dly (
    .clk (clk), .rst (rst), .clr (unl),
    .twox_s (syn.twox), .hclk_s (hclk_s), .vsync_s (syn.vsync),
    .dly (dly_q), .vs (vs_q), .twox_fall (twox_fall)
  );

  always_ff @(posedge clk) begin
    if (rst)         hz_q <= 1'b0;
    else if (!dly_q) hz_q <= syn.csync;
  end

  assign dly_hclk_o  = dly_q;
  assign cmp_sync_o  = gate_pass(syn.csync, dly_q, vs_q);
  assign cmp_ref_o   = gate_pass(hclk_s, dly_q, 1'b0);
  assign hz_o        = hz_q;
  assign unlocked_o  = unl;
  assign clamp_dis_o = unl;
endmodule

// File: rtl/smg_chk.sv
module smg_chk #(
  parameter int LOCK_MAX = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          dly,
  input logic                          vs,
  input logic                          hclk_s,
  input logic                          twox_fall,
  input logic                          cmp_sync,
  input logic                          cmp_ref,
  input logic                          hz,
  input logic                          unlocked,
  input logic [$clog2(LOCK_MAX+1)-1:0] cnt
);
  localparam int CW = $clog2(LOCK_MAX + 1);

  p_dly_capture_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(dly) |-> ($past(twox_fall) && $past(hclk_s)));

  p_dly_masks_both_r2: assert property (@(posedge clk) disable iff (rst)
    dly |-> (!cmp_sync && !cmp_ref));

  p_vert_masks_sync_r3: assert property (@(posedge clk) disable iff (rst)
    vs |-> !cmp_sync);

  p_hz_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    dly |=> $stable(hz));

  p_unlock_clears_r5: assert property (@(posedge clk) disable iff (rst)
    unlocked |=> (!dly && !vs));

  p_unlock_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> (cnt == '0));

  p_lock_at_top_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(unlocked) |-> (cnt == CW'(LOCK_MAX)));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt + 1'b1 == $past(cnt)));

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LOCK_MAX));
endmodule

bind sync_mask_gate smg_chk #(.LOCK_MAX(LOCK_MAX)) chk_i (
  .clk (clk), .rst (rst), .dly (dly_hclk_o), .vs (vs_q), .hclk_s (hclk_s),
  .twox_fall (twox_fall), .cmp_sync (cmp_sync_o), .cmp_ref (cmp_ref_o),
  .hz (hz_o), .unlocked (unlocked_o), .cnt (lock_cnt)
);

// File: tb/sync_mask_gate_tb_top.sv
`timescale 1ns/1ps
module sync_mask_gate_tb_top;
  localparam int LMAX = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic twox_in = 1'b0, hclk_in = 1'b0, csync_in = 1'b0, vsync_in = 1'b0, lock_in = 1'b0;
  logic dly_hclk_o, cmp_sync_o, cmp_ref_o, hz_o, unlocked_o, clamp_dis_o;
  int   ph = 0;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  sync_mask_gate #(.LOCK_MAX(LMAX)) dut_i (
    .clk (clk), .rst (rst), .twox_in (twox_in), .hclk_in (hclk_in),
    .csync_in (csync_in), .vsync_in (vsync_in), .lock_in (lock_in),
    .dly_hclk_o (dly_hclk_o), .cmp_sync_o (cmp_sync_o), .cmp_ref_o (cmp_ref_o),
    .hz_o (hz_o), .unlocked_o (unlocked_o), .clamp_dis_o (clamp_dis_o)
  );

  // Twice-rate reference: 40-cycle period; line clock: 80 cycles, rises with it
  initial forever begin
    @(negedge clk);
    ph = (ph + 1) % 80;
    twox_in = ((ph % 40) < 20);
    hclk_in = (ph < 40);
  end

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_ph(int p);
    @(posedge clk);
    while (ph != p) @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cyc(6);
    chk("R8 unlocked", unlocked_o, 1'b1);
    chk("R8 clamp", clamp_dis_o, 1'b1);
    chk("R8 dly", dly_hclk_o, 1'b0);
    chk("R8 hz", hz_o, 1'b0);
    chk("R8 cmp_sync", cmp_sync_o, 1'b0);
    chk("R8 cmp_ref", cmp_ref_o, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_unlocked_pass();
    lock_in = 1'b0; csync_in = 1'b1; vsync_in = 1'b1;
    cyc(100);
    wait_ph(40);
    chk("R5 dly held low", dly_hclk_o, 1'b0);
    chk("R5 sync unmasked", cmp_sync_o, 1'b1);
    wait_ph(10);
    chk("R5 ref follows hclk", cmp_ref_o, 1'b1);
    chk("R7 clamp while unlocked", clamp_dis_o, 1'b1);
  endtask

  task automatic t_acquire();
    cyc(1);
    lock_in = 1'b1;
    cyc(LMAX);
    chk("R6 still unlocked", unlocked_o, 1'b1);
    cyc(4);
    chk("R6 locked after count", unlocked_o, 1'b0);
    chk("R7 clamp released", clamp_dis_o, 1'b0);
  endtask

  task automatic t_quarter();
    vsync_in = 1'b0; csync_in = 1'b1;
    cyc(100);
    wait_ph(10);
    chk("R1 dly low early in line", dly_hclk_o, 1'b0);
    chk("R2 ref passes", cmp_ref_o, 1'b1);
    chk("R2 sync passes", cmp_sync_o, 1'b1);
    wait_ph(40);
    chk("R1 dly high mid line", dly_hclk_o, 1'b1);
    chk("R2 sync masked", cmp_sync_o, 1'b0);
    chk("R2 ref masked", cmp_ref_o, 1'b0);
    wait_ph(70);
    chk("R1 dly low late in line", dly_hclk_o, 1'b0);
    chk("R2 sync passes late", cmp_sync_o, 1'b1);
  endtask

  task automatic t_vert();
    wait_ph(0);
    vsync_in = 1'b1;
    wait_ph(70);
    chk("R3 sync masked by vertical", cmp_sync_o, 1'b0);
    wait_ph(10);
    chk("R3 ref unaffected", cmp_ref_o, 1'b1);
    chk("R3 sync still masked", cmp_sync_o, 1'b0);
    vsync_in = 1'b0;
    cyc(100);
    wait_ph(70);
    chk("R3 sync restored", cmp_sync_o, 1'b1);
  endtask

  task automatic t_hold();
    csync_in = 1'b0;
    wait_ph(70);
    chk("R4 hz follows low", hz_o, 1'b0);
    wait_ph(30);
    csync_in = 1'b1;
    wait_ph(55);
    chk("R4 hz frozen", hz_o, 1'b0);
    wait_ph(70);
    chk("R4 hz follows after window", hz_o, 1'b1);
  endtask

  task automatic t_hyst();
    lock_in = 1'b0;
    cyc(4);
    lock_in = 1'b1;
    cyc(20);
    chk("R6 short dropout keeps lock", unlocked_o, 1'b0);
    lock_in = 1'b0;
    cyc(LMAX + 6);
    chk("R6 long dropout unlocks", unlocked_o, 1'b1);
    chk("R7 clamp reasserted", clamp_dis_o, 1'b1);
    wait_ph(40);
    chk("R5 dly cleared after unlock", dly_hclk_o, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_unlocked_pass();
    t_acquire();
    t_quarter();
    t_vert();
    t_hold();
    t_hyst();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule